// File: doc/BRIEF.md
# Flash Busy-Status Read Multiplexer

This block forms the byte a flash device returns on a bus read. While an embedded program or erase is running, or after such an operation has failed, every read returns a status byte regardless of the address. At all other times the array byte passes straight through. The command state machine supplies the operation kind and the byte being written when it starts an operation. It also supplies the busy and error flags and a strobe for each bus read. The array supplies the stored byte.

The status byte carries three bits. Bit 7 is a data-polling bit: it shows the inverse of the target bit 7 while programming and shows 0 while erasing. Bit 6 flips after every read, so host software can poll for progress. Bit 5 marks a failed operation. The toggle state survives between reads, and it restarts at 0 whenever a new operation begins. The status path is combinational from the busy and error flags, so the first read after a command already returns status.

Top module: `flsr_status_read`

## Requirements
- R1: While `busy` or `err` is 1, `rd_data` is the status byte, and the value on `array_data` has no effect on it.
- R2: For a program operation (`op_erase`=0 at `op_start`), status bit 7 equals the inverse of bit 7 of `op_data` captured at that start.
- R3: For an erase operation (`op_erase`=1 at `op_start`), status bit 7 reads 0.
- R4: While status is shown, bit 6 flips after each clock cycle in which `rd_stb` is 1. It holds its value in cycles without a strobe.
- R5: With `busy`=0 and `err`=0, `rd_data` equals `array_data`, so a read of the programmed address returns the true bit 7. Reads in this state leave the toggle state unchanged.
- R6: Status bit 5 is 1 exactly when `err` is 1. Bit 6 keeps flipping on reads while `err` is 1.
- R7: Status bits 4 to 0, and any bit above 7, read 0.
- R8: A cycle with `op_start`=1 shows bit 6 as 0, and the toggle state restarts from 0. If a read falls in that same cycle, it returns 0 in bit 6 and the next read returns 1.
- R9: After reset the toggle state is 0 and the captured operation is an erase, so a status read before any start returns 0x00.
- R10: The operation kind and target bit are captured only in a cycle with `op_start`=1. Changes of `op_erase` or `op_data` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_start | input | 1 | One-cycle pulse when a program or erase begins |
| op_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| op_data | input | DATA_W | Byte being programmed, sampled at start |
| busy | input | 1 | Operation in progress |
| err | input | 1 | Operation failed, not yet cleared |
| rd_stb | input | 1 | One cycle per bus read |
| array_data | input | DATA_W | Byte from the storage array |
| rd_data | output | DATA_W | Byte returned to the bus |

## Verification
The start of a new operation and a bus read can fall in the same cycle. Both then act on the toggle state: one clears it and the other advances it. The bench drives `op_start` and `rd_stb` together while `busy` is high. It expects bit 6 at 0 in that cycle and at 1 on the following read, which shows that the clear takes effect before the advance. In the same cycle it also checks that bit 7 comes from the newly supplied operation and not from the captured one.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

    localparam int STAT_W   = 8;
    localparam int POLL_POS = 7;
    localparam int TGL_POS  = 6;
    localparam int FAIL_POS = 5;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     target_msb;
    } op_ctx_t;

    typedef struct packed {
        logic poll;
        logic tgl;
        logic fail;
    } stat_bits_t;

    localparam op_ctx_t CTX_RESET = '{kind: OP_ERASE, target_msb: 1'b0};

    function automatic logic poll_value(op_ctx_t c);
        return (c.kind == OP_ERASE) ? 1'b0 : ~c.target_msb;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(stat_bits_t s);
        logic [STAT_W-1:0] b;
        b           = '0;
        b[POLL_POS] = s.poll;
        b[TGL_POS]  = s.tgl;
        b[FAIL_POS] = s.fail;
        return b;
    endfunction

endpackage

// File: rtl/flsr_op_ctx.sv
module flsr_op_ctx
    import flsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    op_start,
    input  logic    op_erase,
    input  logic    target_msb,
    output op_ctx_t ctx_eff
);
    op_ctx_t ctx_q;
    op_ctx_t ctx_new;

    always_comb begin
        ctx_new.kind       = op_erase ? OP_ERASE : OP_PROGRAM;
        ctx_new.target_msb = target_msb;
        ctx_eff            = op_start ? ctx_new : ctx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= CTX_RESET;
        end else if (op_start) begin
            ctx_q <= ctx_new;
        end
    end
endmodule

// File: rtl/flsr_toggle.sv
module flsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic tgl_eff
);
    logic tgl_q;
    logic tgl_next;

    always_comb begin
        tgl_eff  = clear ? 1'b0 : tgl_q;
        tgl_next = advance ? ~tgl_eff : tgl_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= tgl_next;
        end
    end
endmodule

// File: rtl/flsr_read_mux.sv
module flsr_read_mux
    import flsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              busy,
    input  logic              err,
    input  op_ctx_t           ctx,
    input  logic              tgl,
    input  logic [DATA_W-1:0] array_data,
    output logic              status_sel,
    output logic [DATA_W-1:0] rd_data
);
    stat_bits_t        sbits;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_sel  = busy | err;
        sbits.poll  = poll_value(ctx);
        sbits.tgl   = tgl;
        sbits.fail  = err;
        status_word = '0;
        status_word[STAT_W-1:0] = pack_status(sbits);
        rd_data     = status_sel ? status_word : array_data;
    end
endmodule

// File: rtl/flsr_status_read.sv
module flsr_status_read
    import flsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic              op_erase,
    input  logic [DATA_W-1:0] op_data,
    input  logic              busy,
    input  logic              err,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MSB_POS = STAT_W - 1;

    op_ctx_t ctx_eff;
    logic    tgl_eff;
    logic    status_sel;
    logic    tgl_advance;

    generate
        if (DATA_W < STAT_W) begin : g_bad_width
            initial $error("DATA_W must be at least %0d", STAT_W);
        end
    endgenerate

    assign tgl_advance = rd_stb & status_sel;

    flsr_op_ctx u_ctx (
        .clk        (clk),
        .rst        (rst),
        .op_start   (op_start),
        .op_erase   (op_erase),
        .target_msb (op_data[MSB_POS]),
        .ctx_eff    (ctx_eff)
    );

    flsr_toggle u_tgl (
        .clk     (clk),
        .rst     (rst),
        .clear   (op_start),
        .advance (tgl_advance),
        .tgl_eff (tgl_eff)
    );

    flsr_read_mux #(.DATA_W(DATA_W)) u_mux (
        .busy       (busy),
        .err        (err),
        .ctx        (ctx_eff),
        .tgl        (tgl_eff),
        .array_data (array_data),
        .status_sel (status_sel),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/flsr_status_read_chk.sv
module flsr_status_read_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_start,
    input logic              op_erase,
    input logic [DATA_W-1:0] op_data,
    input logic              busy,
    input logic              err,
    input logic              rd_stb,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data
);
    logic shown;
    assign shown = busy | err;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !shown |-> rd_data == array_data);                               // R5
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        shown |-> rd_data[4:0] == 5'd0);                                 // R7
    AST_FAIL_BIT: assert property (@(posedge clk) disable iff (rst)
        shown |-> rd_data[5] == err);                                    // R6
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (shown && rd_stb && !op_start) |=>
        (!(busy | err) || op_start || rd_data[6] != $past(rd_data[6]))); // R4
    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (shown && !rd_stb && !op_start) |=>
        (!(busy | err) || op_start || rd_data[6] == $past(rd_data[6]))); // R4
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (shown && op_start) |-> !rd_data[6]);                            // R8
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (shown && op_start && op_erase) |-> !rd_data[7]);                // R3
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (shown && op_start && !op_erase) |-> rd_data[7] == !op_data[7]); // R2
    AST_POLL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (shown && !op_start) |=>
        (!(busy | err) || op_start || rd_data[7] == $past(rd_data[7]))); // R10
endmodule

bind flsr_status_read flsr_status_read_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_start   (op_start),
    .op_erase   (op_erase),
    .op_data    (op_data),
    .busy       (busy),
    .err        (err),
    .rd_stb     (rd_stb),
    .array_data (array_data),
    .rd_data    (rd_data)
);

// File: tb/flsr_status_read_tb.sv
module flsr_status_read_tb_top;
    localparam int DW = 8;

    typedef struct packed {
        logic       st;
        logic       er;
        logic [7:0] d;
        logic       bsy;
        logic       err;
        logic       rd;
        logic [7:0] arr;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,8'hA5,8'hA5,4'd5},  // R5 idle read
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,8'h3C,8'h3C,4'd5},  // R5
        '{1'b1,1'b0,8'h80,1'b1,1'b0,1'b0,8'h55,8'h00,4'd2},  // R2 program, msb 1
        '{1'b0,1'b1,8'h00,1'b1,1'b0,1'b1,8'h55,8'h00,4'd10}, // R10 inputs change
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'hFF,8'h40,4'd4},  // R4
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'hFF,8'h00,4'd4},  // R4
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,8'h11,8'h40,4'd4},  // R4 hold
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'h22,8'h40,4'd4},  // R4
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,8'h80,8'h80,4'd5},  // R5 true bit 7
        '{1'b1,1'b0,8'h00,1'b1,1'b0,1'b1,8'h00,8'h80,4'd8},  // R8 start+read
        '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,8'h00,8'hC0,4'd8},  // R8
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,8'hA0,4'd6},  // R6 error
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,8'h00,8'hE0,4'd6},  // R6
        '{1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,8'h12,8'hA0,4'd1},  // R1
        '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,8'h12,8'h12,4'd5},  // R5
        '{1'b1,1'b1,8'hFF,1'b1,1'b0,1'b1,8'h77,8'h00,4'd3},  // R3 erase
        '{1'b0,1'b0,8'hFF,1'b1,1'b0,1'b1,8'h77,8'h40,4'd3},  // R3
        '{1'b0,1'b0,8'h00,1'b1,1'b1,1'b1,8'h77,8'h20,4'd6}   // R6 busy+err
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          op_start, op_erase, busy, err, rd_stb;
    logic [DW-1:0] op_data, array_data, rd_data;
    int            total = 0;
    int            bad   = 0;
    bit            done  = 0;

    always #4 clk = ~clk;

    flsr_status_read #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .op_start(op_start), .op_erase(op_erase),
        .op_data(op_data), .busy(busy), .err(err), .rd_stb(rd_stb),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic check(input logic [7:0] exp, input string req);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic drive(input logic st, input logic er, input logic [7:0] d,
                         input logic bs, input logic e, input logic rd,
                         input logic [7:0] arr);
        @(negedge clk);
        op_start = st; op_erase = er; op_data = d;
        busy = bs; err = e; rd_stb = rd; array_data = arr;
        #1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_start = 0; op_erase = 0; op_data = 0;
        busy = 0; err = 0; rd_stb = 0; array_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R9: reset state is erase context with toggle 0
        drive(0, 0, 8'h00, 1, 0, 0, 8'hC3);
        check(8'h00, "R9 reset status");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].st, VECS[i].er, VECS[i].d, VECS[i].bsy,
                  VECS[i].err, VECS[i].rd, VECS[i].arr);
            total++;
            if (rd_data !== VECS[i].exp) begin
                bad++;
                $display("FAIL R%0d vec %0d: rd_data=%02h expected=%02h",
                         VECS[i].req, i, rd_data, VECS[i].exp);
            end
        end

        // R7: low bits of target never leak into status
        drive(1, 0, 8'h7F, 1, 0, 1, 8'hFF);
        check(8'h80, "R7 start low bits");
        drive(0, 0, 8'h7F, 1, 0, 1, 8'hFF);
        check(8'hC0, "R7 second read");

        // R1: array data ignored while busy
        drive(0, 0, 8'h00, 1, 0, 0, 8'h00);
        check(8'h80, "R1 array 00");
        drive(0, 0, 8'h00, 1, 0, 0, 8'hFF);
        check(8'h80, "R1 array FF");

        // R9: reset mid-operation clears toggle and context
        drive(0, 0, 8'h00, 1, 0, 1, 8'h33);
        check(8'h80, "R9 pre-reset read");
        @(negedge clk); rst = 1'b1; rd_stb = 0;
        @(negedge clk); rst = 1'b0;
        drive(0, 0, 8'h00, 1, 0, 0, 8'h33);
        check(8'h00, "R9 after reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule